// File: doc/BRIEF.md
# Serial ADC Frame Capture Engine

This block runs a 12-bit successive-approximation converter that has a three-wire serial link: an active-low select, a serial clock and a serial data line from the converter. The serial clock is divided down from the system clock. When a request arrives, the block raises a conversion-start pulse of fixed width. It then pulls the select line low and issues exactly 16 serial clocks. The first 4 bits of each frame are dummy bits and are dropped. The last 12 bits form the sample and arrive most significant bit first.

Each finished sample appears on a parallel bus with a one-cycle valid strobe. The strobe comes in the cycle the select line returns high, so it marks the end of that sample's own acquisition. An optional decimation stage sums 16 consecutive samples and outputs the sum divided by 16. A request that comes in while a conversion is still running is dropped and counted in a saturating counter.

Top module: `adc_frame_capture`

## Requirements
- R1: A `start` pulse seen while idle makes `conv` high for exactly CONV_CYC (8) system clocks while `cs_n` stays high. `cs_n` goes low in the cycle after `conv` falls, and `conv` is never high while `cs_n` is low.
- R2: While `cs_n` is low, `sclk` gives exactly 16 rising edges. Each serial period is SYS_DIV (8) system clocks: the first half is low and the second half is high. `sclk` is low whenever `cs_n` is high.
- R3: `sdo` is captured in the first system clock of each high phase of `sclk`. Bits 1 to 4 of the frame are discarded. Bits 5 to 16 fill `sample`, and bit 5 becomes `sample[11]` (MSB first).
- R4: `cs_n` returns high only after the high phase of the 16th serial clock has ended. `sample_vld` pulses for one cycle in the first cycle that `cs_n` is high again. That is CONV_CYC + 16*SYS_DIV system clocks after the clock edge that accepted `start`.
- R5: A `start` that arrives while `conv` is high or `cs_n` is low has no effect on the frame in progress. It starts no later frame and is not queued.
- R6: Each ignored `start` cycle raises `ovr_cnt` by one. The counter saturates at its all-ones value (7 when OVR_W=3).
- R7: When AVG_EN=1, every 16th `sample_vld` is followed one cycle later by a one-cycle `avg_vld`. `avg` then equals the sum of those 16 samples shifted right by 4. The sum then restarts from zero, and `avg_vld` stays low at all other times.
- R8: After reset, `cs_n`=1, `sclk`=0, `conv`=0, `sample_vld`=0, `avg_vld`=0 and `ovr_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion |
| sdo | input | 1 | Serial data from converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to converter |
| conv | output | 1 | Conversion-start pulse |
| sample | output | DATA_BITS | Last captured sample |
| sample_vld | output | 1 | One-cycle strobe for `sample` |
| avg | output | DATA_BITS | Decimated average of 16 samples |
| avg_vld | output | 1 | One-cycle strobe for `avg` |
| ovr_cnt | output | OVR_W | Saturating count of ignored requests |

## Verification
Some rules are checked on every cycle by the assertions:
- `conv` and a low `cs_n` never overlap, and `sclk` stays low outside a frame.
- `sample_vld` comes only on the rising edge of `cs_n`, and `avg_vld` only follows a sample strobe.
- The overrun counter holds once it is saturated, and no conversion starts directly out of a frame.

Other behaviour only the bench scenarios can show:
- the bit order and the dropped dummy bits;
- the exact 16-edge count and the latency;
- the average value over 16 random samples;
- that late requests really start nothing.

// File: rtl/adc_frame_capture.sv
`timescale 1ns/1ps
module adc_frame_capture #(
  parameter int SYS_DIV    = 8,
  parameter int CONV_CYC   = 8,
  parameter int DUMMY_BITS = 4,
  parameter int DATA_BITS  = 12,
  parameter int AVG_EN     = 1,
  parameter int AVG_LOG2   = 4,
  parameter int OVR_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sdo,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 conv,
  output logic [DATA_BITS-1:0] sample,
  output logic                 sample_vld,
  output logic [DATA_BITS-1:0] avg,
  output logic                 avg_vld,
  output logic [OVR_W-1:0]     ovr_cnt
);
  localparam int FRAME_BITS = DUMMY_BITS + DATA_BITS;
  localparam int HALF       = SYS_DIV / 2;
  localparam int DW         = $clog2(SYS_DIV);
  localparam int CW         = $clog2(CONV_CYC);
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int ACC_W      = DATA_BITS + AVG_LOG2;

  typedef enum logic [1:0] {IDLE, CONV, FRAME} st_t;

  st_t                  st;
  logic [DW-1:0]        div;
  logic [CW-1:0]        ccnt;
  logic [BW-1:0]        bcnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 busy;

  assign busy = (st != IDLE);
  assign conv = (st == CONV);
  assign cs_n = (st != FRAME);
  assign sclk = (st == FRAME) && (div >= DW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      div        <= '0;
      ccnt       <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st   <= CONV;
          ccnt <= '0;
        end
        CONV: if (ccnt == CW'(CONV_CYC - 1)) begin
          st   <= FRAME;
          div  <= '0;
          bcnt <= '0;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
        FRAME: begin
          if (div == DW'(HALF) && bcnt >= BW'(DUMMY_BITS))
            shreg <= {shreg[DATA_BITS-2:0], sdo};
          if (div == DW'(SYS_DIV - 1)) begin
            div <= '0;
            if (bcnt == BW'(FRAME_BITS - 1)) begin
              st         <= IDLE;
              sample     <= shreg;
              sample_vld <= 1'b1;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovr_cnt <= '0;
    else if (start && busy && ovr_cnt != '1)
      ovr_cnt <= ovr_cnt + 1'b1;
  end

  generate
    if (AVG_EN != 0) begin : g_avg
      logic [ACC_W-1:0]    acc;
      logic [AVG_LOG2-1:0] n;
      logic [ACC_W-1:0]    sum;
      assign sum = acc + ACC_W'(sample);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc     <= '0;
          n       <= '0;
          avg     <= '0;
          avg_vld <= 1'b0;
        end else begin
          avg_vld <= 1'b0;
          if (sample_vld) begin
            if (n == '1) begin
              avg     <= sum[ACC_W-1:AVG_LOG2];
              avg_vld <= 1'b1;
              acc     <= '0;
              n       <= '0;
            end else begin
              acc <= sum;
              n   <= n + 1'b1;
            end
          end
        end
      end
    end else begin : g_noavg
      assign avg     = '0;
      assign avg_vld = 1'b0;
    end
  endgenerate

  // R1
  conv_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> cs_n);
  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R4
  vld_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (cs_n && $past(!cs_n)));
  // R4
  frame_end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sample_vld);
  // R5
  no_direct_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !conv);
  // R6
  ovr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt == '1) |=> (ovr_cnt == '1));
  // R7
  avg_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld |-> $past(sample_vld));
endmodule

// File: tb/adc_frame_capture_tb.sv
`timescale 1ns/1ps
module adc_frame_capture_tb;
  localparam int SYS_DIV = 8;
  localparam int CONV_CYC = 8;
  localparam int LAT = CONV_CYC + 16 * SYS_DIV + 1;
  localparam int OVR_MAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b0;
  logic cs_n, sclk, conv, sample_vld, avg_vld;
  logic [11:0] sample, avg;
  logic [2:0] ovr_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] word = '0;
  bit in_fr = 1'b0;
  int idx = 0;
  int rises = 0;
  int conv_cyc = 0;
  int cs_low = 0;
  int nsamp = 0;
  int sum = 0;
  int ovr_exp = 0;

  always #10 clk = ~clk;

  adc_frame_capture #(.OVR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .conv(conv),
    .sample(sample), .sample_vld(sample_vld),
    .avg(avg), .avg_vld(avg_vld), .ovr_cnt(ovr_cnt));

  // converter model: bit shifted out on select fall and on each falling sclk
  always @(negedge cs_n or negedge sclk) begin
    if (!cs_n) begin
      if (!in_fr) begin
        in_fr = 1'b1;
        idx = 0;
      end else begin
        idx++;
      end
      sdo = (idx < 16) ? word[15 - idx] : 1'b0;
    end
  end
  always @(posedge cs_n) begin
    in_fr = 1'b0;
    sdo = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) rises++;
  always @(negedge clk) begin
    if (conv) conv_cyc++;
    if (!cs_n) cs_low++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int avg_of(input int s);
    return s >> 4;
  endfunction

  function automatic int sat_add(input int a, input int b);
    return (a + b > OVR_MAX) ? OVR_MAX : a + b;
  endfunction

  task automatic run_frame(input logic [11:0] val, input logic [3:0] dmy,
                           input int n_ovr, input bit full);
    int k;
    word = {dmy, val};
    rises = 0;
    conv_cyc = 0;
    cs_low = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 1;
    while (!sample_vld && k < 3000) begin
      @(negedge clk);
      k++;
      start = (n_ovr > 0 && k >= 20 && k < 20 + n_ovr);
    end
    start = 1'b0;
    nsamp++;
    sum += val;
    ovr_exp = sat_add(ovr_exp, n_ovr);
    chk(sample == val, "R3 sample", sample, val);
    if (full) begin
      chk(k == LAT, "R4 latency", k, LAT);
      chk(conv_cyc == CONV_CYC, "R1 conv width", conv_cyc, CONV_CYC);
      chk(rises == 16, "R2 sclk edges", rises, 16);
      chk(cs_low == 16 * SYS_DIV, "R2 select low cycles", cs_low, 16 * SYS_DIV);
    end
    @(negedge clk);
    chk(sample_vld == 1'b0, "R4 strobe one cycle", sample_vld, 0);
    chk(avg_vld == (nsamp % 16 == 0), "R7 avg strobe", avg_vld, nsamp % 16 == 0);
    if (nsamp % 16 == 0) begin
      chk(avg == 12'(avg_of(sum)), "R7 avg value", avg, avg_of(sum));
      sum = 0;
    end
    chk(ovr_cnt == 3'(ovr_exp), "R6 overrun count", ovr_cnt, ovr_exp);
    if (n_ovr > 0) begin
      int busy_seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (conv || !cs_n) busy_seen++;
      end
      chk(busy_seen == 0, "R5 ignored request", busy_seen, 0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R8 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R8 sclk", sclk, 0);
    chk(conv == 1'b0, "R8 conv", conv, 0);
    chk(sample_vld == 1'b0, "R8 sample_vld", sample_vld, 0);
    chk(avg_vld == 1'b0, "R8 avg_vld", avg_vld, 0);
    chk(ovr_cnt == 3'd0, "R8 ovr_cnt", ovr_cnt, 0);

    run_frame(12'h000, 4'hF, 0, 1'b1);
    run_frame(12'hFFF, 4'h0, 0, 1'b1);
    run_frame(12'hA5A, 4'h5, 0, 1'b1);
    run_frame(12'h5A5, 4'hA, 2, 1'b1);
    run_frame(12'h801, 4'h9, 0, 1'b0);
    for (int f = 0; f < 27; f++)
      run_frame(12'($urandom), 4'($urandom), 0, (f % 5 == 0));
    run_frame(12'h3C3, 4'h6, 9, 1'b1);
    run_frame(12'h001, 4'hE, 1, 1'b0);
    for (int f = 0; f < 16; f++)
      run_frame(12'hFFF - 12'(f), 4'($urandom), 0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule